// File: doc/BRIEF.md
# UART Host Register Front End

This block is the register file that a 32-bit host bus sees in front of a simple serial port. It keeps one transmit holding byte and one receive holding byte. Both are reached through a single data register whose two flag bits carry the handshake. The host queues a character by writing it together with the transmit flag. It learns that a character has arrived when the receive flag reads as 1, and it releases that character by writing the receive flag back.

Beside the data register there is a control register, a clock configuration register, an interrupt status register and an interrupt enable register. The control register holds the parity mode, the break request and the host interrupt gate, and it reports whether any enabled event is pending. The clock configuration word is only stored and passed out to the bit timing logic. The status register collects receive, transmit-done and overrun events. The host clears these bits by writing ones to them, and the enable register masks them before they reach the single interrupt line.

Bus reads are combinational from the register address and have no side effects. Writes take effect at the clock edge on which `bus_wr` is high. On the serial side, the block offers the held transmit byte through a valid/ready pair and takes received bytes on a one-cycle strobe.

Top module: `uart_host_regs`

## Requirements
- R1: After reset the data register (offset 0x00) reads 0x200, which is transmit flag bit 9 = 1, receive flag bit 8 = 0 and character bits 7:0 = 0. Control (0x04), interrupt status (0x0C) and interrupt enable (0x10) read 0, and `tx_valid` and `irq` are 0.
- R2: A write to 0x00 with bit 9 set, while the holding byte is empty, loads bits 7:0. From the next cycle `tx_valid` is 1 with that byte and bit 9 reads 0. Both the byte and `tx_valid` hold until a cycle with `tx_ready` high. A transmit write while the byte is held is ignored.
- R3: A cycle with `rx_strobe` high while the receive flag is clear captures `rx_byte`. From the next cycle, reads of 0x00 return bit 8 = 1 with the byte in bits 7:0. While the flag is clear, bits 7:0 read 0.
- R4: A write to 0x00 with bit 8 set clears the receive flag. A write to 0x00 with bit 8 clear leaves the held received byte and its flag unchanged.
- R5: A strobe that arrives while the receive flag is set and is not being cleared in the same cycle drops the new byte, keeps the held byte and sets sticky status bit 2 (overrun). A strobe in the same cycle as a clearing write is captured and does not set the overrun bit.
- R6: Status bit 0 sets on every captured byte. Status bit 1 sets in the cycle the held transmit byte is accepted (`tx_valid` and `tx_ready`), which is when the transmitter becomes ready again.
- R7: Writing 1 to a bit of 0x0C clears that status bit and writing 0 leaves it unchanged. A set event in the same cycle as a clear leaves the bit at 1.
- R8: The interrupt enable register 0x10 stores bits 2:0, and the other bits read 0. Control bit 4 is read-only and reads 1 exactly when status AND enable is nonzero.
- R9: `irq` is 1 exactly when control bit 3 (host interrupt enable) is 1 and status AND enable is nonzero.
- R10: Control bits 1:0 select parity, with 0 none, 1 even and 2 odd. A written value of 3 is stored as 0. Bit 2 is the break request and drives `tx_break`. `parity_mode` shows bits 1:0. Writes to bit 4 have no effect.
- R11: The clock configuration register at 0x08 is a full 32-bit read/write register whose value drives `clk_cfg`.
- R12: Every offset other than 0x00, 0x04, 0x08, 0x0C and 0x10 reads 0, and writes to such an offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tx_valid | output | 1 | Holding byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| tx_byte | output | 8 | Byte offered to the transmitter |
| rx_strobe | input | 1 | Received byte present for one cycle |
| rx_byte | input | 8 | Received byte |
| parity_mode | output | 2 | Parity selection (0 none, 1 even, 2 odd) |
| tx_break | output | 1 | Break request to the transmitter |
| clk_cfg | output | 32 | Clock configuration word |
| irq | output | 1 | Host interrupt line |

## Verification
The hardest cases are the same-cycle collisions. One is a clearing write to the data register in the very cycle a new byte is strobed in. The other is a write-one-to-clear of status bit 0 in the cycle a capture sets it again. Both can only be reached by putting a bus write and a receive strobe on the same clock edge. The bench therefore drives them through one combined cycle task that sets both sides at the same falling edge. Overrun is reached by strobing twice without a clearing write, and the bench then checks that the first byte is still held.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 5;
    localparam int CHAR_W = 8;
    localparam int NUM_EV = 3;

    localparam logic [ADDR_W-1:0] OFF_DATA  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_CLK   = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_ISTAT = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_IMASK = 5'h10;

    // data register flag positions
    localparam int DAT_RXF = CHAR_W;
    localparam int DAT_TXF = CHAR_W + 1;

    // event bit positions
    localparam int EV_RX  = 0;
    localparam int EV_TX  = 1;
    localparam int EV_OVR = 2;

    // control bit positions
    localparam int CTL_BRK = 2;
    localparam int CTL_HIE = 3;
    localparam int CTL_SUM = 4;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2
    } parity_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_CTRL,
        SEL_CLK,
        SEL_ISTAT,
        SEL_IMASK
    } reg_sel_e;

    typedef struct packed {
        logic    hie;
        logic    brk;
        parity_e par;
    } ctrl_t;

    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        case (a)
            OFF_DATA:  return SEL_DATA;
            OFF_CTRL:  return SEL_CTRL;
            OFF_CLK:   return SEL_CLK;
            OFF_ISTAT: return SEL_ISTAT;
            OFF_IMASK: return SEL_IMASK;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic parity_e clean_parity(logic [1:0] v);
        case (v)
            2'd1:    return PAR_EVEN;
            2'd2:    return PAR_ODD;
            default: return PAR_NONE;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_byte,
    input  logic         tx_ready,
    output logic         tx_valid,
    output logic [W-1:0] tx_byte,
    output logic         can_accept,
    output logic         done_evt
);

    logic         full_q;
    logic [W-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            byte_q <= '0;
        end else if (load && !full_q) begin
            full_q <= 1'b1;
            byte_q <= load_byte;
        end else if (full_q && tx_ready) begin
            full_q <= 1'b0;
        end
    end

    assign tx_valid   = full_q;
    assign tx_byte    = byte_q;
    assign can_accept = !full_q;
    assign done_evt   = full_q && tx_ready;

    // R2: offered byte held until taken
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    // R2: taken byte frees the holding register
    a_r2_release: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> can_accept);

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_strobe,
    input  logic [W-1:0] rx_byte,
    input  logic         pop,
    output logic         has_data,
    output logic [W-1:0] data,
    output logic         cap_evt,
    output logic         ovr_evt
);

    logic         full_q;
    logic [W-1:0] data_q;
    logic         busy;

    assign busy    = full_q && !pop;
    assign cap_evt = rx_strobe && !busy;
    assign ovr_evt = rx_strobe && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (cap_evt) begin
            full_q <= 1'b1;
            data_q <= rx_byte;
        end else if (pop) begin
            full_q <= 1'b0;
        end
    end

    assign has_data = full_q;
    assign data     = data_q;

    // R5: a dropped byte leaves the held byte untouched
    a_r5_drop_keeps: assert property (@(posedge clk) disable iff (rst)
        (rx_strobe && has_data && !pop) |=> (has_data && $stable(data)));

    // R4: a clearing write with no new byte empties the holder
    a_r4_pop_clears: assert property (@(posedge clk) disable iff (rst)
        (pop && !rx_strobe) |=> !has_data);

    // R3: a strobe always leaves a byte held
    a_r3_capture: assert property (@(posedge clk) disable iff (rst)
        rx_strobe |=> has_data);

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_evt,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    input  logic         en_wr,
    input  logic [N-1:0] en_wdata,
    output logic [N-1:0] status,
    output logic [N-1:0] enable,
    output logic         pending
);

    logic [N-1:0] status_q;
    logic [N-1:0] enable_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                status_q[i] <= 1'b0;
            end else begin
                status_q[i] <= set_evt[i] || (status_q[i] && !(clr_wr && clr_mask[i]));
            end
        end

        // R7: write-one clears a bit that is not being set
        a_r7_w1c: assert property (@(posedge clk) disable iff (rst)
            (clr_wr && clr_mask[i] && !set_evt[i]) |=> !status[i]);

        // R7: set wins over clear
        a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_evt[i] |=> status[i]);

        // R7: zero written leaves the bit alone
        a_r7_zero_keeps: assert property (@(posedge clk) disable iff (rst)
            (status[i] && !(clr_wr && clr_mask[i])) |=> status[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
        end else if (en_wr) begin
            enable_q <= en_wdata;
        end
    end

    assign status  = status_q;
    assign enable  = enable_q;
    assign pending = |(status_q & enable_q);

endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
    import uart_regs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BUS_W,
    parameter int CW = CHAR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [CW-1:0] tx_byte,
    input  logic          rx_strobe,
    input  logic [CW-1:0] rx_byte,
    output logic [1:0]    parity_mode,
    output logic          tx_break,
    output logic [DW-1:0] clk_cfg,
    output logic          irq
);

    reg_sel_e      sel;
    logic          wr_data, wr_ctrl, wr_clk, wr_istat, wr_imask;
    logic          tx_load, rx_pop;
    logic          tx_can, tx_done;
    logic          rx_has;
    logic [CW-1:0] rx_data;
    logic          rx_cap, rx_ovr;
    logic [NUM_EV-1:0] ev_set, ev_status, ev_enable;
    logic          ev_pending;
    ctrl_t         ctrl_q;
    logic [DW-1:0] clk_q;

    assign sel      = decode_addr(bus_addr);
    assign wr_data  = bus_wr && (sel == SEL_DATA);
    assign wr_ctrl  = bus_wr && (sel == SEL_CTRL);
    assign wr_clk   = bus_wr && (sel == SEL_CLK);
    assign wr_istat = bus_wr && (sel == SEL_ISTAT);
    assign wr_imask = bus_wr && (sel == SEL_IMASK);
    assign tx_load  = wr_data && bus_wdata[DAT_TXF];
    assign rx_pop   = wr_data && bus_wdata[DAT_RXF];

    uart_tx_hold #(.W(CW)) tx_i (
        .clk        (clk),
        .rst        (rst),
        .load       (tx_load),
        .load_byte  (bus_wdata[CW-1:0]),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .tx_byte    (tx_byte),
        .can_accept (tx_can),
        .done_evt   (tx_done)
    );

    uart_rx_hold #(.W(CW)) rx_i (
        .clk       (clk),
        .rst       (rst),
        .rx_strobe (rx_strobe),
        .rx_byte   (rx_byte),
        .pop       (rx_pop),
        .has_data  (rx_has),
        .data      (rx_data),
        .cap_evt   (rx_cap),
        .ovr_evt   (rx_ovr)
    );

    always_comb begin
        ev_set         = '0;
        ev_set[EV_RX]  = rx_cap;
        ev_set[EV_TX]  = tx_done;
        ev_set[EV_OVR] = rx_ovr;
    end

    uart_irq_ctrl #(.N(NUM_EV)) ev_i (
        .clk      (clk),
        .rst      (rst),
        .set_evt  (ev_set),
        .clr_wr   (wr_istat),
        .clr_mask (bus_wdata[NUM_EV-1:0]),
        .en_wr    (wr_imask),
        .en_wdata (bus_wdata[NUM_EV-1:0]),
        .status   (ev_status),
        .enable   (ev_enable),
        .pending  (ev_pending)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{hie: 1'b0, brk: 1'b0, par: PAR_NONE};
            clk_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.par <= clean_parity(bus_wdata[1:0]);
                ctrl_q.brk <= bus_wdata[CTL_BRK];
                ctrl_q.hie <= bus_wdata[CTL_HIE];
            end
            if (wr_clk) begin
                clk_q <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_DATA: begin
                bus_rdata[DAT_TXF]  = tx_can;
                bus_rdata[DAT_RXF]  = rx_has;
                bus_rdata[CW-1:0]   = rx_has ? rx_data : '0;
            end
            SEL_CTRL: begin
                bus_rdata[1:0]      = ctrl_q.par;
                bus_rdata[CTL_BRK]  = ctrl_q.brk;
                bus_rdata[CTL_HIE]  = ctrl_q.hie;
                bus_rdata[CTL_SUM]  = ev_pending;
            end
            SEL_CLK:   bus_rdata = clk_q;
            SEL_ISTAT: bus_rdata[NUM_EV-1:0] = ev_status;
            SEL_IMASK: bus_rdata[NUM_EV-1:0] = ev_enable;
            default:   bus_rdata = '0;
        endcase
    end

    assign parity_mode = ctrl_q.par;
    assign tx_break    = ctrl_q.brk;
    assign clk_cfg     = clk_q;
    assign irq         = ctrl_q.hie && ev_pending;

    // R9: the line stays low while the host gate is off
    a_r9_gate: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.hie |-> !irq);

    // R10: the reserved parity code is never stored
    a_r10_parity_legal: assert property (@(posedge clk) disable iff (rst)
        parity_mode != 2'd3);

    // R6: an accepted transmit byte raises the transmit event
    a_r6_tx_event: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> ev_status[EV_TX]);

    // R5: an overrun raises the sticky bit
    a_r5_overrun: assert property (@(posedge clk) disable iff (rst)
        (rx_strobe && rx_has && !rx_pop) |=> ev_status[EV_OVR]);

endmodule

// File: tb/uart_host_regs_tb_top.sv
`timescale 1ns/1ps
module uart_host_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_byte;
    logic        rx_strobe = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [1:0]  parity_mode;
    logic        tx_break;
    logic [31:0] clk_cfg;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    uart_host_regs dut_i (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .tx_byte     (tx_byte),
        .rx_strobe   (rx_strobe),
        .rx_byte     (rx_byte),
        .parity_mode (parity_mode),
        .tx_break    (tx_break),
        .clk_cfg     (clk_cfg),
        .irq         (irq)
    );

    // vector: {req[3:0], is_write, addr[4:0], data[31:0]}
    localparam int NV = 14;
    localparam logic [41:0] VEC [NV] = '{
        {4'd10, 1'b1, 5'h04, 32'h0000_000E},  // R10 odd parity, break, gate
        {4'd10, 1'b0, 5'h04, 32'h0000_000E},
        {4'd10, 1'b1, 5'h04, 32'h0000_0013},  // R10 code 3 stored as none, bit 4 ignored
        {4'd10, 1'b0, 5'h04, 32'h0000_0000},
        {4'd11, 1'b1, 5'h08, 32'hA5C3_1234},  // R11
        {4'd11, 1'b0, 5'h08, 32'hA5C3_1234},
        {4'd8,  1'b1, 5'h10, 32'hFFFF_FFFF},  // R8 only bits 2:0 kept
        {4'd8,  1'b0, 5'h10, 32'h0000_0007},
        {4'd12, 1'b1, 5'h14, 32'hDEAD_BEEF},  // R12 unmapped write
        {4'd12, 1'b0, 5'h14, 32'h0000_0000},
        {4'd12, 1'b0, 5'h1C, 32'h0000_0000},
        {4'd12, 1'b0, 5'h08, 32'hA5C3_1234},
        {4'd8,  1'b1, 5'h10, 32'h0000_0000},
        {4'd8,  1'b0, 5'h10, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // one clock cycle of combined stimulus, driven at the falling edge
    task automatic cyc(input logic wr, input logic [4:0] a, input logic [31:0] d,
                       input logic stb, input logic [7:0] b);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        rx_strobe = stb; rx_byte = b;
        @(negedge clk);
        bus_wr = 1'b0; rx_strobe = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, 8'h00);
    endtask

    task automatic rxb(input logic [7:0] b);
        cyc(1'b0, 5'h00, 32'h0, 1'b1, b);
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd("R1 data", 5'h00, 32'h0000_0200);
        rd("R1 ctrl", 5'h04, 32'h0);
        rd("R1 istat", 5'h0C, 32'h0);
        rd("R1 imask", 5'h10, 32'h0);
        chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // register table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][37]) begin
                wr(VEC[i][36:32], VEC[i][31:0]);
            end else begin
                bus_addr = VEC[i][36:32];
                #1;
                checks++;
                if (bus_rdata !== VEC[i][31:0]) begin
                    fails++;
                    $display("FAIL R%0d table[%0d]: actual 0x%08h expected 0x%08h",
                             VEC[i][41:38], i, bus_rdata, VEC[i][31:0]);
                end
            end
        end
        chk("R11 clk_cfg", clk_cfg, 32'hA5C3_1234);

        // R10 control outputs
        wr(5'h04, 32'h0000_0006);
        chk("R10 parity_mode", {30'b0, parity_mode}, 32'h2);
        chk("R10 tx_break", {31'b0, tx_break}, 32'h1);
        wr(5'h04, 32'h0000_0001);
        chk("R10 even", {30'b0, parity_mode}, 32'h1);
        chk("R10 break off", {31'b0, tx_break}, 32'h0);
        wr(5'h04, 32'h0);

        // R2 transmit holding
        wr(5'h00, 32'h0000_02A5);
        chk("R2 tx_valid", {31'b0, tx_valid}, 32'h1);
        chk("R2 tx_byte", {24'b0, tx_byte}, 32'hA5);
        rd("R2 busy flag", 5'h00, 32'h0000_0000);
        wr(5'h00, 32'h0000_0211);
        chk("R2 ignored load", {24'b0, tx_byte}, 32'hA5);
        chk("R2 still valid", {31'b0, tx_valid}, 32'h1);
        rd("R6 no tx event yet", 5'h0C, 32'h0);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
        chk("R2 released", {31'b0, tx_valid}, 32'h0);
        rd("R6 tx event", 5'h0C, 32'h2);
        rd("R2 ready flag", 5'h00, 32'h0000_0200);

        // R7 write-one-to-clear
        wr(5'h0C, 32'h0);
        rd("R7 zero keeps", 5'h0C, 32'h2);
        wr(5'h0C, 32'h2);
        rd("R7 one clears", 5'h0C, 32'h0);

        // R3 receive capture
        rxb(8'h5C);
        rd("R3 captured", 5'h00, 32'h0000_035C);
        rd("R6 rx event", 5'h0C, 32'h1);

        // R5 overrun
        rxb(8'h77);
        rd("R5 held byte kept", 5'h00, 32'h0000_035C);
        rd("R5 overrun bit", 5'h0C, 32'h5);

        // R4 clearing write
        wr(5'h00, 32'h0000_0000);
        rd("R4 no flag no pop", 5'h00, 32'h0000_035C);
        wr(5'h00, 32'h0000_0100);
        rd("R4 popped", 5'h00, 32'h0000_0200);

        // R5 pop and strobe in the same cycle
        wr(5'h0C, 32'h7);
        rxb(8'h01);
        cyc(1'b1, 5'h00, 32'h0000_0100, 1'b1, 8'h02);
        rd("R5 same-cycle capture", 5'h00, 32'h0000_0302);
        rd("R5 no overrun", 5'h0C, 32'h1);

        // R7 set beats clear
        wr(5'h00, 32'h0000_0100);
        cyc(1'b1, 5'h0C, 32'h0000_0001, 1'b1, 8'h33);
        rd("R7 set wins", 5'h0C, 32'h1);
        rd("R3 second byte", 5'h00, 32'h0000_0333);

        // R8 / R9 masking and gate
        wr(5'h10, 32'h1);
        rd("R8 summary", 5'h04, 32'h0000_0010);
        chk("R9 gate off", {31'b0, irq}, 32'h0);
        wr(5'h04, 32'h0000_0008);
        chk("R9 irq on", {31'b0, irq}, 32'h1);
        rd("R8 summary with gate", 5'h04, 32'h0000_0018);
        wr(5'h10, 32'h2);
        chk("R9 masked", {31'b0, irq}, 32'h0);
        rd("R8 masked summary", 5'h04, 32'h0000_0008);
        wr(5'h10, 32'h1);
        chk("R9 unmasked", {31'b0, irq}, 32'h1);
        wr(5'h0C, 32'h1);
        chk("R9 cleared", {31'b0, irq}, 32'h0);

        finish_run();
    end

endmodule